// File: doc/BRIEF.md
# Manchester Bi-Phase Word Transmitter

This block turns one 16-bit payload into a 20-bit-time serial bus word on a single line. Each word has three parts, sent in this order: a 3-bit-time synchronisation pattern, the 16 payload bits sent most significant bit first, and one parity bit. The sync pattern deliberately breaks the Manchester rules. A receiver uses it to find the start of the word. Its polarity tells the receiver whether the word is a command/status word or a data word. The payload and parity bits use Manchester-II bi-phase code.

A producer offers a payload and a word-type flag through a valid/ready handshake. The block divides the system clock down to half-bit ticks at twice the bit rate. Each word starts on the first tick after it is accepted. The block drives an output-enable for exactly the span of the word, because the bus is half-duplex and must be released between transmissions. A second word offered while the first is finishing is accepted on the final tick of the first word. It then follows with no idle half-bit between the two.

The control state machine has five states:
- `ST_IDLE`: nothing held, ready high, line released.
- `ST_ARMED`: a word is held and the block waits for the next tick.
- `ST_SYNC`: the six sync half-bits are being sent.
- `ST_INFO`: the 32 payload half-bits are being sent.
- `ST_PAR`: the two parity half-bits are being sent.

The transitions are:
- accept: `ST_IDLE` to `ST_ARMED`.
- start: `ST_ARMED` to `ST_SYNC` on a tick.
- sync done: `ST_SYNC` to `ST_INFO` after the sixth half-bit.
- payload done: `ST_INFO` to `ST_PAR` after the 32nd payload half-bit.
- release: `ST_PAR` to `ST_IDLE` on the final tick when no word is offered.
- chain: `ST_PAR` to `ST_SYNC` on the final tick when a new word is accepted in that same cycle.

Top module: `mbp_word_tx`

## Requirements
- R1: `bus_oe` rises at the start of a word and stays high for exactly 40 half-bit intervals per word sent. It then falls, unless a chained word follows.
- R2: A word with `in_is_cmd`=1 begins with three half-bits high followed by three half-bits low.
- R3: A word with `in_is_cmd`=0 begins with three half-bits low followed by three half-bits high.
- R4: After the sync, the 16 payload bits follow, bit 15 first. A 1 is sent as high then low, and a 0 as low then high, each half lasting one half-bit interval.
- R5: The last two half-bits carry a parity bit, coded as in R4. Its value makes the count of ones over the 16 payload bits plus parity odd.
- R6: While `bus_oe` is low, `bus_line` is low, including any idle time between words.
- R7: `in_ready` is high when idle. It is low from the cycle after a word is accepted until the word's final half-bit interval ends.
- R8: A word accepted in the cycle where the previous word's final half-bit ends starts its first sync half-bit at once. `bus_oe` stays high across the two words and no gap appears.
- R9: One half-bit interval lasts CLK_HZ/(2*BIT_HZ) clock cycles. `bus_line` and `bus_oe` change only at half-bit boundaries.
- R10: A word accepted while idle appears on `bus_oe` between 1 and CLK_HZ/(2*BIT_HZ) clock cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | INFO_W | Payload, bit INFO_W-1 sent first |
| in_is_cmd | input | 1 | 1: command/status sync, 0: data sync |
| bus_line | output | 1 | Encoded serial line level |
| bus_oe | output | 1 | High while the block drives the line |

## Verification
A wrong half-bit counter shows up at the ports as a region boundary in the wrong place. The sync would then be longer or shorter than three half-bits, or `bus_oe` would fall before or after the 40th interval, within one word time. A stale or unshifted payload register corrupts the payload half-bits as soon as the second bit is sent. A wrong parity latch shows up only in the last two half-bits, so words with even and odd payload weight are both sent. A state machine that drops or repeats its armed state shows up as a missing word or a gap between chained words. It can also show up as a start latency longer than one tick period.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SYNC,
        ST_INFO,
        ST_PAR
    } tx_state_t;

    localparam int SYNC_HALVES = 6;
    localparam int PAR_HALVES  = 2;

endpackage

// File: rtl/mbp_tick_gen.sv
module mbp_tick_gen #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    // DIV must be at least 2 so that a tick never appears two cycles in a row.
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mbp_word_reg.sv
module mbp_word_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_cmd,
    input  logic         shift,
    output logic         msb,
    output logic         is_cmd,
    output logic         par_bit
);
    logic [W-1:0] sreg_q;
    logic         cmd_q;
    logic         par_q;

    assign msb     = sreg_q[W-1];
    assign is_cmd  = cmd_q;
    assign par_bit = par_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cmd_q  <= 1'b0;
            par_q  <= 1'b0;
        end else if (load) begin
            sreg_q <= load_data;
            cmd_q  <= load_cmd;
            par_q  <= ~(^load_data);
        end else if (shift) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mbp_word_tx.sv
module mbp_word_tx #(
    parameter int CLK_HZ = 250_000_000,
    parameter int BIT_HZ = 1_000_000,
    parameter int INFO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INFO_W-1:0] in_data,
    input  logic              in_is_cmd,
    output logic              bus_line,
    output logic              bus_oe
);
    import mbp_pkg::*;

    localparam int DIV         = CLK_HZ / (2 * BIT_HZ);
    localparam int WORD_HALVES = SYNC_HALVES + 2 * INFO_W + PAR_HALVES;
    localparam int HW          = $clog2(WORD_HALVES + 1);
    localparam int SYNC_END    = SYNC_HALVES - 1;
    localparam int INFO_END    = SYNC_HALVES + 2 * INFO_W - 1;
    localparam int LAST        = WORD_HALVES - 1;
    localparam int SYNC_FIRST  = SYNC_HALVES / 2;

    tx_state_t     state_q, state_n;
    logic [HW-1:0] hidx_q, hidx_n, nxt_h, info_off;
    logic          tick, active, last_tick, accept, start_now, shift;
    logic          msb, is_cmd, par_bit;
    logic          line_q, line_n, oe_q, oe_n;

    mbp_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    mbp_word_reg #(.W(INFO_W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (in_data),
        .load_cmd  (in_is_cmd),
        .shift     (shift),
        .msb       (msb),
        .is_cmd    (is_cmd),
        .par_bit   (par_bit)
    );

    assign active    = (state_q == ST_SYNC) || (state_q == ST_INFO) || (state_q == ST_PAR);
    assign last_tick = tick && active && (hidx_q == HW'(LAST));
    assign in_ready  = (state_q == ST_IDLE) || last_tick;
    assign accept    = in_valid && in_ready;
    assign start_now = ((state_q == ST_ARMED) && tick) || (last_tick && accept);
    assign nxt_h     = hidx_q + 1'b1;
    assign info_off  = nxt_h - HW'(SYNC_HALVES);
    // Shift on the edge that sends a payload bit's second half.
    assign shift     = tick && active && !last_tick &&
                       (nxt_h >= HW'(SYNC_HALVES)) && (nxt_h <= HW'(INFO_END)) && info_off[0];

    // Next-state logic.
    always_comb begin
        state_n = state_q;
        hidx_n  = hidx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (tick) begin
                    state_n = ST_SYNC;
                    hidx_n  = '0;
                end
            end
            ST_SYNC: begin
                if (tick) begin
                    hidx_n = nxt_h;
                    if (hidx_q == HW'(SYNC_END)) state_n = ST_INFO;
                end
            end
            ST_INFO: begin
                if (tick) begin
                    hidx_n = nxt_h;
                    if (hidx_q == HW'(INFO_END)) state_n = ST_PAR;
                end
            end
            ST_PAR: begin
                if (last_tick) begin
                    hidx_n  = '0;
                    state_n = accept ? ST_SYNC : ST_IDLE;
                end else if (tick) begin
                    hidx_n = nxt_h;
                end
            end
            default: begin
                state_n = ST_IDLE;
                hidx_n  = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hidx_q  <= '0;
        end else begin
            state_q <= state_n;
            hidx_q  <= hidx_n;
        end
    end

    // Line level for the next half-bit.
    always_comb begin
        line_n = line_q;
        oe_n   = oe_q;
        if (start_now) begin
            oe_n   = 1'b1;
            line_n = (state_q == ST_ARMED) ? is_cmd : in_is_cmd;
        end else if (last_tick) begin
            oe_n   = 1'b0;
            line_n = 1'b0;
        end else if (tick && active) begin
            oe_n = 1'b1;
            if (nxt_h < HW'(SYNC_HALVES)) begin
                line_n = (nxt_h < HW'(SYNC_FIRST)) ? is_cmd : ~is_cmd;
            end else if (nxt_h <= HW'(INFO_END)) begin
                line_n = info_off[0] ? ~msb : msb;
            end else begin
                line_n = (nxt_h == HW'(LAST)) ? ~par_bit : par_bit;
            end
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            line_q <= line_n;
            oe_q   <= oe_n;
        end
    end

    assign bus_line = line_q;
    assign bus_oe   = oe_q;
endmodule

// File: rtl/mbp_word_tx_chk.sv
module mbp_word_tx_chk #(
    parameter int DIV         = 125,
    parameter int WORD_HALVES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic in_valid,
    input logic in_ready,
    input logic bus_line,
    input logic bus_oe
);
    logic [31:0] run_len, oe_len;
    logic        line_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            oe_len  <= '0;
            line_d  <= 1'b0;
        end else begin
            line_d <= bus_line;
            if (!bus_oe)                 run_len <= '0;
            else if (bus_line != line_d) run_len <= 32'd1;
            else                         run_len <= run_len + 32'd1;
            if (bus_oe) oe_len <= oe_len + 32'd1;
            else        oe_len <= '0;
        end
    end

    // R6: the line rests low while released.
    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> !bus_line);

    // R9: outputs move only on half-bit ticks.
    p_half_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(bus_line) && $stable(bus_oe)));

    // R7: ready drops after an acceptance.
    p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2: no level lasts longer than four half-bits (sync plus an adjacent half).
    p_run_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (run_len <= 32'(4 * DIV)));

    // R1: the drive window is a whole number of words.
    p_whole_words_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> ((oe_len % 32'(WORD_HALVES * DIV)) == 32'd0));
endmodule

bind mbp_word_tx mbp_word_tx_chk #(
    .DIV         (DIV),
    .WORD_HALVES (WORD_HALVES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .bus_line (bus_line),
    .bus_oe   (bus_oe)
);

// File: tb/test_mbp_word_tx.sv
`timescale 1ns/1ps
module test_mbp_word_tx;
    localparam int CLK_HZ = 8_000_000;
    localparam int BIT_HZ = 1_000_000;
    localparam int DIV    = CLK_HZ / (2 * BIT_HZ);
    localparam int W      = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         in_is_cmd = 1'b0;
    logic         bus_line, bus_oe;
    int           n_chk = 0;
    int           n_fail = 0;

    always #2 clk = ~clk;

    mbp_word_tx #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .INFO_W(W)) i_mbp_word_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_is_cmd(in_is_cmd), .bus_line(bus_line), .bus_oe(bus_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] halves_of(input logic [15:0] d, input logic c);
        logic [39:0] r;
        logic        p;
        r[39:34] = c ? 6'b111000 : 6'b000111;
        for (int i = 0; i < 16; i++) r[33-2*i -: 2] = d[15-i] ? 2'b10 : 2'b01;
        p = ~(^d);
        r[1:0] = p ? 2'b10 : 2'b01;
        return r;
    endfunction

    task automatic send(input logic [15:0] d, input logic c);
        in_valid  = 1'b1;
        in_data   = d;
        in_is_cmd = c;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Called at a negedge; waits for oe, then samples the middle of each half-bit.
    task automatic capture(input int halves, output logic [79:0] got, output int lat,
                           output bit oe_drop, output bit rdy_high,
                           output logic end_oe, output logic end_line, output logic end_rdy);
        got = '0; lat = 0; oe_drop = 0; rdy_high = 0;
        while (!bus_oe && lat < 20 * DIV) begin
            lat++;
            @(negedge clk);
        end
        for (int k = 0; k < halves; k++) begin
            got[79-k] = bus_line;
            if (!bus_oe)  oe_drop  = 1;
            if (in_ready) rdy_high = 1;
            repeat (DIV) @(negedge clk);
        end
        end_oe   = bus_oe;
        end_line = bus_line;
        end_rdy  = in_ready;
    endtask

    task automatic check_word(input logic [39:0] got, input logic [39:0] exp, input logic c);
        check(got[39:34] == exp[39:34], c ? "R2" : "R3", "sync halves", 64'(got[39:34]), 64'(exp[39:34]));
        check(got[33:2] == exp[33:2], "R4", "payload halves", 64'(got[33:2]), 64'(exp[33:2]));
        check(got[1:0] == exp[1:0], "R5", "parity halves", 64'(got[1:0]), 64'(exp[1:0]));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(bus_oe == 1'b0, "R6", "reset oe", 64'(bus_oe), 64'd0);
        check(bus_line == 1'b0, "R6", "reset line", 64'(bus_line), 64'd0);
        check(in_ready == 1'b1, "R7", "reset ready", 64'(in_ready), 64'd1);
    endtask

    task automatic t_single(input logic [15:0] d, input logic c);
        logic [79:0] got;
        int          lat;
        bit          od, rh;
        logic        eo, el, er;
        send(d, c);
        capture(40, got, lat, od, rh, eo, el, er);
        check(lat >= 1 && lat <= DIV, "R10", "start latency", 64'(lat), 64'(DIV));
        check_word(got[79:40], halves_of(d, c), c);
        check(!od, "R1", "oe held over word", 64'(od), 64'd0);
        check(!rh, "R7", "ready low during word", 64'(rh), 64'd0);
        check(eo == 1'b0, "R1", "oe after 40 halves", 64'(eo), 64'd0);
        check(el == 1'b0, "R6", "line after word", 64'(el), 64'd0);
        check(er == 1'b1, "R7", "ready after word", 64'(er), 64'd1);
    endtask

    task automatic t_sync_len();
        int n = 0;
        send(16'h0000, 1'b1);
        while (!bus_oe) @(negedge clk);
        while (bus_line) begin
            n++;
            @(negedge clk);
        end
        check(n == 3 * DIV, "R9", "cycles of first sync level", 64'(n), 64'(3 * DIV));
        while (bus_oe) @(negedge clk);
    endtask

    task automatic t_chain();
        logic [79:0] got;
        int          lat;
        bit          od, rh;
        logic        eo, el, er;
        fork
            begin
                send(16'hB3A1, 1'b1);
                send(16'h7289, 1'b0);
            end
            capture(80, got, lat, od, rh, eo, el, er);
        join
        check_word(got[79:40], halves_of(16'hB3A1, 1'b1), 1'b1);
        check_word(got[39:0], halves_of(16'h7289, 1'b0), 1'b0);
        check(!od, "R8", "oe gap between chained words", 64'(od), 64'd0);
        check(!rh, "R7", "ready low across chain", 64'(rh), 64'd0);
        check(eo == 1'b0, "R1", "oe after two words", 64'(eo), 64'd0);
    endtask

    task automatic t_idle_gap();
        bit seen = 0;
        repeat (10 * DIV) begin
            @(negedge clk);
            if (bus_oe || bus_line) seen = 1;
        end
        check(!seen, "R6", "line quiet with no word offered", 64'(seen), 64'd0);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single(16'hB3A1, 1'b1);
        t_single(16'h7289, 1'b0);
        t_single(16'h0000, 1'b0);
        t_single(16'hFFFF, 1'b1);
        t_single(16'h0001, 1'b0);
        t_sync_len();
        t_chain();
        t_idle_gap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule